// File: doc/BRIEF.md
# Three-Wire Serial Clock-Calendar Slave

This block sits behind a four-bit general-purpose pin word and acts as the slave side of a three-wire serial clock-calendar link. Each time the host presents a new pin word, the block compares it with the word it saw last. From that comparison it detects a chip-select start condition and rising serial-clock edges. An eight-bit command is shifted in least significant bit first. The block then either accepts bytes into its control register or streams BCD calendar and time bytes back on the data line. Two commands do not transfer data: one clears the control register and one raises a single-cycle interrupt pulse.

For each accepted pin word the block returns a pin word one cycle later. That word is the incoming word, except on a clock rising edge during a read, where the data line carries the next outgoing bit. The current date and time arrive as parallel BCD inputs from a separate timekeeping block. This block neither counts time nor converts it. The control register exposes three fields to the rest of the chip: a periodic interrupt enable, a 12-hour display mode and a power-loss flag.

Top module: `rtc_serial_engine`

## Requirements
- R1: In idle, the block leaves idle only when a pin word raises chip select (bit 2) from 0 to 1 while the previous word had the clock (bit 0) high. Any other word leaves it in idle.
- R2: Outside idle, the data line (bit 1) is sampled only on a clock rising edge, meaning the previous word had bit 0 low and the new word has it high. Bits of every byte travel least significant first.
- R3: After eight command bits, a command whose bits 7:4 equal 6 is used as received. Any other command is bit-reversed first. In the resulting byte, bit 0 = 1 means read, bit 0 = 0 means write, and bits 3:1 select the register.
- R4: Register 1 (control) is one byte long. After a control read the block is back in idle, so further clock edges return the data line unchanged.
- R5: A read of register 2 returns seven bytes in this order: year, month, day, weekday, hour, minute, second.
- R6: A read of register 3 returns three bytes in this order: hour, minute, second.
- R7: A control write replaces control bits 6:0 and keeps bit 7. Bit 3 drives `periodic_irq_en`, bit 6 drives `hour12_mode` and bit 7 drives `power_lost`.
- R8: A write command to register 0 clears the whole control register and returns to idle.
- R9: A write command to register 6 raises `irq_pulse` for exactly one clock cycle and returns to idle.
- R10: Writes of register 2 (seven bytes) or register 3 (three bytes) are clocked in and discarded. Writes to registers 4, 5 and 7, and reads of registers 0 and 4 to 7, return straight to idle with no effect.
- R11: A pin word with chip select low in any state other than idle aborts to idle with the bit and byte counters cleared. The next transfer starts again from bit 0 of byte 0.
- R12: Every accepted pin word produces `pin_out_valid` one cycle later. `pin_out` then equals that word, except that bit 1 carries the outgoing data bit on a read-state clock rising edge.
- R13: Reset clears the control register and the returned pin word. A high `power_fail` sets control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_valid | input | 1 | A new pin word is present on `pin_in` |
| pin_in | input | 4 | Pin word: bit 0 clock, bit 1 data, bit 2 chip select |
| pin_out | output | 4 | Returned pin word |
| pin_out_valid | output | 1 | `pin_out` holds the response to the previous accepted word |
| bcd_year | input | 8 | Current year, BCD |
| bcd_month | input | 8 | Current month, BCD |
| bcd_day | input | 8 | Current day of month, BCD |
| bcd_weekday | input | 8 | Current weekday, BCD |
| bcd_hour | input | 8 | Current hour, BCD |
| bcd_minute | input | 8 | Current minute, BCD |
| bcd_second | input | 8 | Current second, BCD |
| power_fail | input | 1 | Sets the power-loss flag |
| irq_pulse | output | 1 | One-cycle interrupt request |
| periodic_irq_en | output | 1 | Control bit 3 |
| hour12_mode | output | 1 | Control bit 6 |
| power_lost | output | 1 | Control bit 7 |

## Verification
A bit or byte counter that drifts shows up on the data line at once: the very next read clock edge returns a bit from the wrong position or the wrong byte. The same fault can also end a transfer early, so later clock edges come back unchanged. A wrong state after a command shows within one pin word. Either clock edges echo unchanged where data was due, or data appears where an echo was due. A mis-decoded write only shows on the three control outputs, one cycle after its last bit, or on a missing or doubled interrupt pulse. An abort that fails to clear the counters shows on the first byte of the next read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int PIN_W      = 4;
    localparam int SCK_POS    = 0;
    localparam int SIO_POS    = 1;
    localparam int CS_POS     = 2;
    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int MAX_BYTES  = 7;
    localparam int BYTE_IDX_W = $clog2(MAX_BYTES);

    localparam int CTRL_PIE_POS = 3;
    localparam int CTRL_H12_POS = 6;
    localparam int CTRL_PWR_POS = 7;

    localparam logic [3:0] NO_SWAP_NIBBLE = 4'h6;

    localparam logic [2:0] RID_RESET = 3'd0;
    localparam logic [2:0] RID_CTRL  = 3'd1;
    localparam logic [2:0] RID_DT    = 3'd2;
    localparam logic [2:0] RID_TIME  = 3'd3;
    localparam logic [2:0] RID_IRQ   = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD
    } rtc_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_DT,
        SEL_TIME
    } rtc_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] day;
        logic [BYTE_W-1:0] weekday;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] minute;
        logic [BYTE_W-1:0] second;
    } rtc_bcd_t;

    typedef struct packed {
        logic       rd;
        logic [2:0] idx;
    } cmd_fields_t;

    function automatic logic [BYTE_W-1:0] bit_reverse(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

    function automatic cmd_fields_t unpack_cmd(input logic [BYTE_W-1:0] raw);
        logic [BYTE_W-1:0] fixed;
        cmd_fields_t       f;
        fixed = (raw[7:4] == NO_SWAP_NIBBLE) ? raw : bit_reverse(raw);
        f.rd  = fixed[0];
        f.idx = fixed[3:1];
        return f;
    endfunction

    function automatic logic [BYTE_IDX_W-1:0] xfer_len(input rtc_sel_e s);
        case (s)
            SEL_DT:   return BYTE_IDX_W'(7);
            SEL_TIME: return BYTE_IDX_W'(3);
            default:  return BYTE_IDX_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/rtc_pin_edge.sv
module rtc_pin_edge
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_valid,
    input  logic [PIN_W-1:0] pin_in,
    output logic             sck_rise,
    output logic             start_hit
);

    logic [PIN_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst)            prev_q <= '0;
        else if (pin_valid) prev_q <= pin_in;
    end

    always_comb begin
        sck_rise  = pin_valid && !prev_q[SCK_POS] && pin_in[SCK_POS];
        start_hit = pin_valid && prev_q[SCK_POS] && !prev_q[CS_POS] && pin_in[CS_POS];
    end

endmodule

// File: rtl/rtc_cmd_fsm.sv
module rtc_cmd_fsm
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pin_valid,
    input  logic                  cs_now,
    input  logic                  sio_now,
    input  logic                  sck_rise,
    input  logic                  start_hit,
    output rtc_state_e            state_q,
    output rtc_sel_e              sel_q,
    output logic [BIT_IDX_W-1:0]  bit_q,
    output logic [BYTE_IDX_W-1:0] byte_q,
    output logic                  wr_stb_q,
    output logic [BYTE_W-1:0]     wr_data_q,
    output logic                  clr_q,
    output logic                  irq_q
);

    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] shift_nx;
    logic              byte_end;
    logic              xfer_end;
    cmd_fields_t       cf;

    always_comb begin
        shift_nx        = shreg_q;
        shift_nx[bit_q] = sio_now;
        byte_end        = (bit_q == BIT_IDX_W'(BYTE_W-1));
        xfer_end        = (byte_q == xfer_len(sel_q) - BYTE_IDX_W'(1));
        cf              = unpack_cmd(shift_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sel_q     <= SEL_CTRL;
            bit_q     <= '0;
            byte_q    <= '0;
            shreg_q   <= '0;
            wr_stb_q  <= 1'b0;
            wr_data_q <= '0;
            clr_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            clr_q    <= 1'b0;
            irq_q    <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start_hit) state_q <= ST_CMD;
            end else if (pin_valid && !cs_now) begin
                state_q <= ST_IDLE;
                bit_q   <= '0;
                byte_q  <= '0;
                shreg_q <= '0;
            end else if (sck_rise) begin
                bit_q   <= byte_end ? '0 : bit_q + BIT_IDX_W'(1);
                shreg_q <= byte_end ? '0 : shift_nx;
                case (state_q)
                    ST_CMD: begin
                        if (byte_end) begin
                            state_q <= ST_IDLE;
                            if (cf.rd) begin
                                case (cf.idx)
                                    RID_CTRL: begin state_q <= ST_RD; sel_q <= SEL_CTRL; end
                                    RID_DT:   begin state_q <= ST_RD; sel_q <= SEL_DT;   end
                                    RID_TIME: begin state_q <= ST_RD; sel_q <= SEL_TIME; end
                                    default:  ;
                                endcase
                            end else begin
                                case (cf.idx)
                                    RID_RESET: clr_q <= 1'b1;
                                    RID_CTRL:  begin state_q <= ST_WR; sel_q <= SEL_CTRL; end
                                    RID_DT:    begin state_q <= ST_WR; sel_q <= SEL_DT;   end
                                    RID_TIME:  begin state_q <= ST_WR; sel_q <= SEL_TIME; end
                                    RID_IRQ:   irq_q <= 1'b1;
                                    default:   ;
                                endcase
                            end
                        end
                    end
                    ST_WR, ST_RD: begin
                        if (byte_end) begin
                            if (state_q == ST_WR && sel_q == SEL_CTRL) begin
                                wr_stb_q  <= 1'b1;
                                wr_data_q <= shift_nx;
                            end
                            if (xfer_end) begin
                                state_q <= ST_IDLE;
                                byte_q  <= '0;
                            end else begin
                                byte_q <= byte_q + BYTE_IDX_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: interrupt request lasts one cycle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R1: no start condition keeps idle
    a_r1_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_hit) |=> state_q == ST_IDLE);

    // R11: chip-select drop aborts and clears counters
    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && pin_valid && !cs_now)
        |=> (state_q == ST_IDLE && bit_q == '0 && byte_q == '0));

    // R11: counters are clear whenever idle
    a_r11_idle_clean: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |-> (bit_q == '0 && byte_q == '0));

endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr_req,
    input  logic              power_fail,
    output logic [BYTE_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (clr_req)     ctrl_q <= '0;
            else if (wr_stb) ctrl_q[CTRL_PWR_POS-1:0] <= wr_data[CTRL_PWR_POS-1:0];
            if (power_fail)  ctrl_q[CTRL_PWR_POS] <= 1'b1;
        end
    end

    // R7: the power-loss bit is not writable over the serial link
    a_r7_bit7_ro: assert property (@(posedge clk) disable iff (rst)
        (!clr_req && !power_fail) |=> ctrl_q[CTRL_PWR_POS] == $past(ctrl_q[CTRL_PWR_POS]));

    // R8: clear command empties the register
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !power_fail) |=> ctrl_q == '0);

    // R13: power failure sets the flag
    a_r13_pwr_set: assert property (@(posedge clk) disable iff (rst)
        power_fail |=> ctrl_q[CTRL_PWR_POS]);

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_pkg::*;
(
    input  rtc_bcd_t              bcd,
    input  logic [BYTE_W-1:0]     ctrl,
    input  rtc_sel_e              sel,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic [BIT_IDX_W-1:0]  bit_idx,
    output logic                  rd_bit
);

    logic [BYTE_W-1:0] cur_byte;

    always_comb begin
        cur_byte = '0;
        case (sel)
            SEL_CTRL: cur_byte = ctrl;
            SEL_DT: begin
                case (byte_idx)
                    3'd0:    cur_byte = bcd.year;
                    3'd1:    cur_byte = bcd.month;
                    3'd2:    cur_byte = bcd.day;
                    3'd3:    cur_byte = bcd.weekday;
                    3'd4:    cur_byte = bcd.hour;
                    3'd5:    cur_byte = bcd.minute;
                    3'd6:    cur_byte = bcd.second;
                    default: cur_byte = '0;
                endcase
            end
            SEL_TIME: begin
                case (byte_idx)
                    3'd0:    cur_byte = bcd.hour;
                    3'd1:    cur_byte = bcd.minute;
                    3'd2:    cur_byte = bcd.second;
                    default: cur_byte = '0;
                endcase
            end
            default: cur_byte = '0;
        endcase
        rd_bit = cur_byte[bit_idx];
    end

endmodule

// File: rtl/rtc_serial_engine.sv
module rtc_serial_engine
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_valid,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic             pin_out_valid,
    input  logic [7:0]       bcd_year,
    input  logic [7:0]       bcd_month,
    input  logic [7:0]       bcd_day,
    input  logic [7:0]       bcd_weekday,
    input  logic [7:0]       bcd_hour,
    input  logic [7:0]       bcd_minute,
    input  logic [7:0]       bcd_second,
    input  logic             power_fail,
    output logic             irq_pulse,
    output logic             periodic_irq_en,
    output logic             hour12_mode,
    output logic             power_lost
);

    logic                  sck_rise;
    logic                  start_hit;
    rtc_state_e            state;
    rtc_sel_e              sel;
    logic [BIT_IDX_W-1:0]  bit_idx;
    logic [BYTE_IDX_W-1:0] byte_idx;
    logic                  wr_stb;
    logic [BYTE_W-1:0]     wr_data;
    logic                  clr_req;
    logic [BYTE_W-1:0]     ctrl;
    logic                  rd_bit;
    rtc_bcd_t              bcd;

    assign bcd = '{year: bcd_year, month: bcd_month, day: bcd_day, weekday: bcd_weekday,
                   hour: bcd_hour, minute: bcd_minute, second: bcd_second};

    rtc_pin_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_valid (pin_valid),
        .pin_in    (pin_in),
        .sck_rise  (sck_rise),
        .start_hit (start_hit)
    );

    rtc_cmd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pin_valid (pin_valid),
        .cs_now    (pin_in[CS_POS]),
        .sio_now   (pin_in[SIO_POS]),
        .sck_rise  (sck_rise),
        .start_hit (start_hit),
        .state_q   (state),
        .sel_q     (sel),
        .bit_q     (bit_idx),
        .byte_q    (byte_idx),
        .wr_stb_q  (wr_stb),
        .wr_data_q (wr_data),
        .clr_q     (clr_req),
        .irq_q     (irq_pulse)
    );

    rtc_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .clr_req    (clr_req),
        .power_fail (power_fail),
        .ctrl_q     (ctrl)
    );

    rtc_read_mux u_mux (
        .bcd      (bcd),
        .ctrl     (ctrl),
        .sel      (sel),
        .byte_idx (byte_idx),
        .bit_idx  (bit_idx),
        .rd_bit   (rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out       <= '0;
            pin_out_valid <= 1'b0;
        end else begin
            pin_out_valid <= pin_valid;
            if (pin_valid) begin
                pin_out <= pin_in;
                if (state == ST_RD && pin_in[CS_POS] && sck_rise)
                    pin_out[SIO_POS] <= rd_bit;
            end
        end
    end

    assign periodic_irq_en = ctrl[CTRL_PIE_POS];
    assign hour12_mode     = ctrl[CTRL_H12_POS];
    assign power_lost      = ctrl[CTRL_PWR_POS];

    // R12: response follows every accepted word, clock and select echoed
    a_r12_echo: assert property (@(posedge clk) disable iff (rst)
        pin_valid |=> (pin_out_valid && pin_out[CS_POS] == $past(pin_in[CS_POS])
                       && pin_out[SCK_POS] == $past(pin_in[SCK_POS])));

    // R12: outside a read the data line is echoed
    a_r12_sio_echo: assert property (@(posedge clk) disable iff (rst)
        (pin_valid && state != ST_RD) |=> pin_out[SIO_POS] == $past(pin_in[SIO_POS]));

endmodule

// File: tb/rtc_serial_engine_tb_top.sv
module rtc_serial_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_valid;
    logic [3:0] pin_in;
    logic [3:0] pin_out;
    logic       pin_out_valid;
    logic [7:0] bcd_year, bcd_month, bcd_day, bcd_weekday, bcd_hour, bcd_minute, bcd_second;
    logic       power_fail;
    logic       irq_pulse, periodic_irq_en, hour12_mode, power_lost;

    int checks = 0;
    int errors = 0;
    int irq_count = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] v;
        int         req;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    rtc_serial_engine dut_i (
        .clk             (clk),
        .rst             (rst),
        .pin_valid       (pin_valid),
        .pin_in          (pin_in),
        .pin_out         (pin_out),
        .pin_out_valid   (pin_out_valid),
        .bcd_year        (bcd_year),
        .bcd_month       (bcd_month),
        .bcd_day         (bcd_day),
        .bcd_weekday     (bcd_weekday),
        .bcd_hour        (bcd_hour),
        .bcd_minute      (bcd_minute),
        .bcd_second      (bcd_second),
        .power_fail      (power_fail),
        .irq_pulse       (irq_pulse),
        .periodic_irq_en (periodic_irq_en),
        .hour12_mode     (hour12_mode),
        .power_lost      (power_lost)
    );

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_eq(input int req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per returned pin word
    always @(negedge clk) begin
        if (!rst && pin_out_valid) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12 unexpected pin word: actual 0x%0h expected none", pin_out);
            end else begin
                e = exp_q.pop_front();
                if (pin_out !== e.v) begin
                    errors++;
                    $display("FAIL R%0d pin word: actual 0x%0h expected 0x%0h", e.req, pin_out, e.v);
                end
            end
        end
    end

    always @(posedge clk) if (!rst && irq_pulse) irq_count++;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // driver: one pin word, with its expected response
    task automatic word(input logic [3:0] w, input logic [3:0] e, input int req);
        exp_t x;
        @(negedge clk);
        x.v = e; x.req = req;
        exp_q.push_back(x);
        pin_valid = 1'b1;
        pin_in    = w;
        @(negedge clk);
        pin_valid = 1'b0;
    endtask

    task automatic start_xfer;
        word(4'h1, 4'h1, 1);
        word(4'h5, 4'h5, 1);
    endtask

    task automatic end_xfer;
        word(4'h1, 4'h1, 12);
    endtask

    // sends a byte; the data line holds the wrong value while the clock is low (R2)
    task automatic send_byte(input logic [7:0] b, input int req);
        for (int i = 0; i < 8; i++) begin
            logic [3:0] lo_bad, lo, hi;
            lo_bad = {2'b01, ~b[i], 1'b0};
            lo     = {2'b01,  b[i], 1'b0};
            hi     = {2'b01,  b[i], 1'b1};
            word(lo_bad, lo_bad, req);
            word(lo, lo, req);
            word(hi, hi, req);
        end
    endtask

    task automatic read_bits(input logic [7:0] b, input int n, input int req);
        for (int i = 0; i < n; i++) begin
            word(4'h4, 4'h4, req);
            word(4'h5, {2'b01, b[i], 1'b1}, req);
        end
    endtask

    task automatic read_byte(input logic [7:0] b, input int req);
        read_bits(b, 8, req);
    endtask

    task automatic settle;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        rst = 1'b1; pin_valid = 1'b0; pin_in = 4'h0; power_fail = 1'b0;
        bcd_year = 8'h25; bcd_month = 8'h12; bcd_day = 8'h31; bcd_weekday = 8'h04;
        bcd_hour = 8'h23; bcd_minute = 8'h59; bcd_second = 8'h58;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        check_eq(13, "pin_out after reset", pin_out, 0);
        check_eq(13, "power_lost after reset", power_lost, 0);
        check_eq(13, "periodic after reset", periodic_irq_en, 0);
        check_eq(9, "irq after reset", irq_pulse, 0);

        // R1: select rises with clock low -> no entry; a read command is just echoed
        word(4'h0, 4'h0, 1);
        word(4'h4, 4'h4, 1);
        send_byte(8'h65, 1);
        read_byte(8'h00, 1);
        end_xfer();

        // R7 / R2: control write with a command used as received
        start_xfer(); send_byte(8'h62, 3); send_byte(8'h4A, 7); end_xfer();
        settle();
        check_eq(7, "periodic_irq_en", periodic_irq_en, 1);
        check_eq(7, "hour12_mode", hour12_mode, 1);
        check_eq(7, "power_lost", power_lost, 0);

        // R4: control read is one byte, then clock edges echo
        start_xfer(); send_byte(8'h63, 4); read_byte(8'h4A, 4);
        read_byte(8'h00, 4); end_xfer();

        // R13: power failure sets bit 7
        @(negedge clk) power_fail = 1'b1;
        @(negedge clk) power_fail = 1'b0;
        settle();
        check_eq(13, "power_lost after fail", power_lost, 1);

        // R7: bit 7 kept across a write of zero
        start_xfer(); send_byte(8'h62, 7); send_byte(8'h00, 7); end_xfer();
        settle();
        check_eq(7, "power_lost kept", power_lost, 1);
        check_eq(7, "periodic cleared", periodic_irq_en, 0);
        check_eq(7, "hour12 cleared", hour12_mode, 0);

        // R5: date-time read order
        start_xfer(); send_byte(8'h65, 5);
        read_byte(8'h25, 5); read_byte(8'h12, 5); read_byte(8'h31, 5); read_byte(8'h04, 5);
        read_byte(8'h23, 5); read_byte(8'h59, 5); read_byte(8'h58, 5);
        read_byte(8'h00, 5); end_xfer();

        // R6: time read, command used as received
        start_xfer(); send_byte(8'h67, 6);
        read_byte(8'h23, 6); read_byte(8'h59, 6); read_byte(8'h58, 6);
        read_byte(8'h00, 6); end_xfer();

        // R3: reversed command 0xE5 decodes as a time read
        start_xfer(); send_byte(8'hE5, 3);
        read_byte(8'h23, 3); read_byte(8'h59, 3); read_byte(8'h58, 3);
        read_byte(8'h00, 3); end_xfer();

        // R10: date-time write (reversed 0x20) discarded, then control read unchanged
        start_xfer(); send_byte(8'h20, 10);
        for (int k = 0; k < 7; k++) send_byte(8'hFF, 10);
        start_xfer(); send_byte(8'h63, 10); read_byte(8'h80, 10); end_xfer();
        settle();
        check_eq(10, "ctrl after date write", {power_lost, hour12_mode, periodic_irq_en}, 3'b100);

        // R10: time write (0x66) three bytes, then register 5 write and register 0 read
        start_xfer(); send_byte(8'h66, 10);
        for (int k = 0; k < 3; k++) send_byte(8'hFF, 10);
        start_xfer(); send_byte(8'h6A, 10); read_byte(8'h00, 10); end_xfer();
        start_xfer(); send_byte(8'h80, 10); read_byte(8'h00, 10); end_xfer();
        settle();
        check_eq(10, "ctrl after ignored cmds", {power_lost, hour12_mode, periodic_irq_en}, 3'b100);

        // R8: reset command clears control including bit 7
        start_xfer(); send_byte(8'h00, 8); read_byte(8'h00, 8); end_xfer();
        settle();
        check_eq(8, "power_lost after clear", power_lost, 0);
        start_xfer(); send_byte(8'h63, 8); read_byte(8'h00, 8); end_xfer();

        // R9: interrupt command (reversed 0x30) gives one pulse
        check_eq(9, "irq count before", irq_count, 0);
        start_xfer(); send_byte(8'h30, 9); read_byte(8'h00, 9); end_xfer();
        settle();
        check_eq(9, "irq count after", irq_count, 1);

        // R11: abort mid-read, then a fresh read starts at bit 0 of byte 0
        start_xfer(); send_byte(8'h65, 11);
        read_bits(8'h25, 5, 11);
        word(4'h0, 4'h0, 11);
        start_xfer(); send_byte(8'h65, 11);
        read_byte(8'h25, 11); read_byte(8'h12, 11);
        word(4'h1, 4'h1, 11);
        read_byte(8'h00, 11);
        end_xfer();

        settle();
        check_eq(12, "queue drained", exp_q.size(), 0);
        done = 1;
        report();
    end

endmodule